// File: doc/BRIEF.md
# Register-Mapped SPI Master

A serial-peripheral master controller driven through a small register port of 32-bit words. Software programs a serial clock divisor, the clock polarity and phase, the frame length and bit order, then writes bytes into an eight-entry transmit queue. Whenever the queue holds a byte and the shifter is idle, the controller clocks one frame out on the data-out line and captures the same number of bits from the data-in line into an eight-entry receive queue.

Queue status is folded into bit 31 of the data registers themselves: the transmit data word reports "full" there and the receive data word reports "empty" there, so a driver polls and moves data with a single access. A small bank of chip-select lines has a writable per-line idle level. A mode register chooses whether the selected line is asserted around each frame, held asserted across frames, or never driven away from its idle level.

Only single-lane frames of one to eight bits are built. Register addresses for the multi-lane, flash-read, delay and interrupt functions accept writes and discard them.

Top module: `spi_ctrl`

## Requirements
- R1: After reset every chip-select line is high, offset 0x14 reads all ones, the serial clock is 0, offset 0x4C reads with bit 31 set, offset 0x48 reads with bit 31 clear and offset 0x40 reads a length field (bits 19:16) of 8.
- R2: With divisor d written to bits 11:0 of offset 0x00, every half period of the serial clock lasts d+1 input clock cycles.
- R3: Offset 0x04 bit 0 is phase and bit 1 is polarity; the idle serial clock rests at the polarity level; with phase 0 the data-in line is sampled on the leading edge and data-out changes on the trailing edge, with phase 1 the roles swap.
- R4: In offset 0x40, bits 19:16 give the frame length n (values 1 to 8; 0 or above 8 mean 8) and bit 2 set sends and receives least significant bit first; a frame moves bits n-1..0 of the written byte and the received byte sits right-aligned in bits 7:0 with upper bits zero.
- R5: A write to offset 0x48 enqueues bits 7:0; reading 0x48 returns bit 31 set when eight bytes are waiting; a write while full is dropped.
- R6: Reading offset 0x4C returns the oldest received byte in bits 7:0 and pops it when bit 31 (empty) is clear; the queue holds eight bytes and a frame finishing while it is full loses its byte.
- R7: With bit 3 of offset 0x40 set, frames run but nothing is pushed into the receive queue.
- R8: Frames start back to back as long as the transmit queue is non-empty.
- R9: Offset 0x10 selects the chip-select line; in mode 0 at offset 0x18 (values 1 also behave this way) only the selected line is driven to the inverse of its idle level, and only while a frame runs.
- R10: In mode 2 the selected line stays asserted after a frame until offset 0x10, 0x14 or 0x18 is written.
- R11: In mode 3 every chip-select line stays at its idle level.
- R12: Writing offset 0x14 sets the idle level of each line and takes effect on the next cycle; the asserted level of a line is the inverse of its idle bit.
- R13: Writes to offset 0x60 and to any other unlisted offset change nothing, and reads of those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Chip-select lines |

## Verification
A wrong bit counter or edge phase shows up within one frame as a changed sample count or a shifted received byte, which the bench sees by comparing its own slave model against the receive register and against what the slave captured from the data-out line. A queue pointer error shows as missing, duplicated or reordered bytes when eight-plus bytes are pushed and drained, and as a wrong full or empty flag in bit 31 on the next access. A stuck hold flag or wrong chip-select mode shows on the chip-select pins in the cycle after the releasing write.

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
  parameter int NCS   = 4,
  parameter int DEPTH = 8,
  parameter int DIVW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = (NCS > 1) ? $clog2(NCS) : 1;

  logic [DIVW-1:0] div;
  logic            cpha, cpol, f_lsb, f_dir, hold;
  logic [3:0]      f_len;
  logic [IW-1:0]   cs_idx;
  logic [NCS-1:0]  cs_def;
  logic [1:0]      cs_mode;

  logic wr, rd;
  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;
  logic wr_cs;
  assign wr_cs = wr && (bus_addr == 8'h10 || bus_addr == 8'h14 || bus_addr == 8'h18);

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:20], bus_wdata[15:12]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= DIVW'(3); cpha <= 1'b0; cpol <= 1'b0;
      cs_idx <= '0; cs_def <= '1; cs_mode <= 2'd0;
      f_lsb <= 1'b0; f_dir <= 1'b0; f_len <= 4'd8;
    end else if (wr) begin
      case (bus_addr)
        8'h00: div <= bus_wdata[DIVW-1:0];
        8'h04: begin cpha <= bus_wdata[0]; cpol <= bus_wdata[1]; end
        8'h10: cs_idx <= bus_wdata[IW-1:0];
        8'h14: cs_def <= bus_wdata[NCS-1:0];
        8'h18: cs_mode <= bus_wdata[1:0];
        8'h40: begin f_lsb <= bus_wdata[2]; f_dir <= bus_wdata[3]; f_len <= bus_wdata[19:16]; end
        default: ;
      endcase
    end
  end

  // queues
  logic [7:0] txq [DEPTH];
  logic [7:0] rxq [DEPTH];
  logic [AW:0] tx_wp, tx_rp, rx_wp, rx_rp, tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_push, rx_push, rx_pop, start;
  logic busy;

  assign tx_cnt   = tx_wp - tx_rp;
  assign rx_cnt   = rx_wp - rx_rp;
  assign tx_full  = tx_cnt == (AW+1)'(DEPTH);
  assign rx_full  = rx_cnt == (AW+1)'(DEPTH);
  assign tx_empty = tx_cnt == '0;
  assign rx_empty = rx_cnt == '0;
  assign tx_push  = wr && bus_addr == 8'h48 && !tx_full;
  assign rx_pop   = rd && bus_addr == 8'h4C && !rx_empty;
  assign start    = !busy && !tx_empty;

  // shifter
  logic [DIVW-1:0] dcnt;
  logic [4:0]      ecnt;
  logic [7:0]      tsr, rsr, head, load, rx_res;
  logic [3:0]      a_len, eff_len;
  logic            a_lsb, a_dir, a_pha, sck_i;
  logic            tick, done, lead, samp, shft;

  assign head    = txq[tx_rp[AW-1:0]];
  assign eff_len = (f_len == 4'd0 || f_len > 4'd8) ? 4'd8 : f_len;
  assign load    = f_lsb ? {<<{head}} : head << (4'd8 - eff_len);
  assign tick    = busy && dcnt >= div;
  assign done    = tick && ecnt == {a_len, 1'b0};
  assign lead    = ~ecnt[0];
  assign samp    = tick && !done && (lead ^ a_pha);
  assign shft    = tick && !done && !(lead ^ a_pha) && !(a_pha && ecnt == 5'd0);
  assign rx_res  = a_lsb ? ({<<{rsr}} >> (4'd8 - a_len)) : rsr;
  assign rx_push = done && !a_dir && !rx_full;

  always_ff @(posedge clk) begin
    if (tx_push) txq[tx_wp[AW-1:0]] <= bus_wdata[7:0];
    if (rx_push) rxq[rx_wp[AW-1:0]] <= rx_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; dcnt <= '0; ecnt <= '0; sck_i <= 1'b0;
      tsr <= '0; rsr <= '0; a_len <= 4'd8; a_lsb <= 1'b0; a_dir <= 1'b0; a_pha <= 1'b0;
    end else if (start) begin
      busy <= 1'b1; dcnt <= '0; ecnt <= '0; sck_i <= 1'b0;
      tsr <= load; rsr <= '0; a_len <= eff_len; a_lsb <= f_lsb; a_dir <= f_dir; a_pha <= cpha;
    end else if (busy) begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) begin
        if (done) busy <= 1'b0;
        else begin sck_i <= ~sck_i; ecnt <= ecnt + 1'b1; end
        if (samp) rsr <= {rsr[6:0], miso};
        if (shft) tsr <= {tsr[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     hold <= 1'b0;
    else if (wr_cs) hold <= 1'b0;
    else if (start) hold <= 1'b1;
  end

  logic cs_act;
  assign cs_act = (cs_mode == 2'd3) ? 1'b0 : (cs_mode == 2'd2) ? (busy | hold) : busy;

  always_comb
    for (int i = 0; i < NCS; i++)
      cs_n[i] = cs_def[i] ^ (cs_act && cs_idx == IW'(i));

  assign sclk = sck_i ^ cpol;
  assign mosi = tsr[7];

  always_comb begin
    case (bus_addr)
      8'h00:   bus_rdata = 32'(div);
      8'h04:   bus_rdata = {30'd0, cpol, cpha};
      8'h10:   bus_rdata = 32'(cs_idx);
      8'h14:   bus_rdata = 32'(cs_def);
      8'h18:   bus_rdata = {30'd0, cs_mode};
      8'h40:   bus_rdata = {12'd0, f_len, 12'd0, f_dir, f_lsb, 2'b00};
      8'h48:   bus_rdata = {tx_full, 31'd0};
      8'h4C:   bus_rdata = {rx_empty, 23'd0, rxq[rx_rp[AW-1:0]]};
      default: bus_rdata = 32'd0;
    endcase
  end

  assert_edge_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_i) |-> $past(dcnt) >= $past(div));
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (AW+1)'(DEPTH));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= (AW+1)'(DEPTH));
  assert_auto_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_mode == 2'd0 && !busy) |-> cs_n == cs_def);
  assert_off_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_mode == 2'd3 |-> cs_n == cs_def);
endmodule

// File: tb/spi_ctrl_test.sv
`timescale 1ns/1ps
module spi_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso;
  logic [3:0] cs_n;

  spi_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;

  // slave model
  logic loop = 1'b0, m_pol = 1'b0, m_pha = 1'b0;
  logic [7:0] sl_byte = '0, cap = '0;
  int sl_k = 0, samples = 0;
  longint last_t = 0, half_ns = 0;
  logic [3:0] cs_low_acc = '0, cs_hi_acc = '0;

  assign miso = loop ? mosi : sl_byte[3'(7 - sl_k)];

  always @(sclk) if (cs_n != 4'hF) begin
    if (last_t > 0) half_ns = $time - last_t;
    last_t = $time;
    if ((sclk != m_pol) == !m_pha) begin
      cap = {cap[6:0], mosi};
      sl_k++;
      samples++;
    end
  end

  always @(negedge clk) begin
    cs_low_acc |= ~cs_n;
    cs_hi_acc  |= cs_n;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic get_rx(output logic [31:0] v);
    v = 32'h8000_0000;
    for (int g = 0; g < 5000 && v[31]; g++) rd(8'h4C, v);
  endtask

  function automatic int nlen(input logic [3:0] lf);
    return (lf == 0 || lf > 8) ? 8 : int'(lf);
  endfunction

  function automatic logic [7:0] exp_wire(input logic [7:0] d, input logic lsb, input int n);
    logic [7:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = lsb ? d[n-1-i] : d[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_rx(input logic [7:0] s, input logic lsb, input int n);
    logic [7:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = lsb ? s[7-i] : s[8-n+i];
    return r;
  endfunction

  // {pha, pol, lsb, len field, div, tx byte, slave byte}
  localparam logic [26:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 4'd8,  4'd1, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 1'b0, 4'd8,  4'd0, 8'hC3, 8'h96},
    {1'b0, 1'b1, 1'b1, 4'd8,  4'd2, 8'h81, 8'h7E},
    {1'b1, 1'b1, 1'b0, 4'd5,  4'd1, 8'h1B, 8'hF0},
    {1'b0, 1'b0, 1'b1, 4'd3,  4'd0, 8'h05, 8'hA0},
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd1, 8'h6E, 8'h55},
    {1'b0, 1'b1, 1'b0, 4'd12, 4'd0, 8'h9A, 8'hC9}
  };

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 32'h0);
    rd(8'h14, v); chk("R1 cs default", v, 32'hF);
    rd(8'h4C, v); chk("R1 rx empty", 32'(v[31]), 32'h1);
    rd(8'h48, v); chk("R1 tx not full", 32'(v[31]), 32'h0);
    rd(8'h40, v); chk("R1 length", 32'(v[19:16]), 32'h8);

    // R3 R4 R2 table of frames
    for (int t = 0; t < 7; t++) begin
      logic [26:0] e;
      int n;
      e = VEC[t];
      n = nlen(e[23:20]);
      m_pha = e[26]; m_pol = e[25];
      wr(8'h04, {30'd0, e[25], e[26]});
      wr(8'h00, 32'(e[19:16]));
      wr(8'h40, {12'd0, e[23:20], 13'd0, e[24], 2'b00});
      sl_byte = e[7:0]; sl_k = 0; cap = '0; samples = 0; last_t = 0;
      @(negedge clk);
      chk("R3 idle clock level", 32'(sclk), 32'(e[25]));
      wr(8'h48, 32'(e[15:8]));
      get_rx(v);
      chk("R4 R3 received byte", v, 32'(exp_rx(e[7:0], e[24], n)));
      chk("R4 R3 byte on wire", 32'(cap & 8'((1 << n) - 1)), 32'(exp_wire(e[15:8], e[24], n)));
      chk("R4 sample count", 32'(samples), 32'(n));
      chk("R2 half period", 32'(half_ns), 32'((e[19:16] + 1) * 10));
      chk("R3 clock returns idle", 32'(sclk), 32'(e[25]));
    end

    // R2 larger divisor
    m_pha = 0; m_pol = 0;
    wr(8'h04, 0); wr(8'h40, 32'h0008_0000); wr(8'h00, 32'd6);
    last_t = 0;
    wr(8'h48, 32'h5A); get_rx(v);
    chk("R2 half period div 6", 32'(half_ns), 32'd70);

    // R5 R6 R8 queues, loopback
    loop = 1'b1; samples = 0;
    wr(8'h00, 32'd3);
    for (int i = 1; i <= 9; i++) wr(8'h48, 32'(i));
    rd(8'h48, v); chk("R5 tx full flag", 32'(v[31]), 32'h1);
    wr(8'h48, 32'h0A);
    repeat (900) @(negedge clk);
    chk("R8 R5 back to back frames, extra byte dropped", 32'(samples), 32'd72);
    for (int i = 1; i <= 8; i++) begin
      rd(8'h4C, v); chk("R6 rx order", v, 32'(i));
    end
    rd(8'h4C, v); chk("R6 full queue drops byte", 32'(v[31]), 32'h1);
    rd(8'h48, v); chk("R5 tx drained", 32'(v[31]), 32'h0);

    // R7 direction bit
    wr(8'h00, 32'd1); wr(8'h40, 32'h0008_0008);
    wr(8'h48, 32'h33);
    repeat (80) @(negedge clk);
    rd(8'h4C, v); chk("R7 rx discarded", 32'(v[31]), 32'h1);
    wr(8'h40, 32'h0008_0000);

    // R9 chip-select index, auto mode
    wr(8'h10, 32'd2);
    cs_low_acc = '0;
    wr(8'h48, 32'h11); get_rx(v);
    chk("R9 only line 2 asserted", 32'(cs_low_acc), 32'h4);
    chk("R9 released after frame", 32'(cs_n), 32'hF);

    // R10 hold mode
    wr(8'h18, 32'd2);
    wr(8'h48, 32'h22); get_rx(v);
    chk("R10 held after frame", 32'(cs_n), 32'hB);
    wr(8'h48, 32'h23); get_rx(v);
    chk("R10 held across frames", 32'(cs_n), 32'hB);
    wr(8'h18, 32'd0);
    chk("R10 mode write releases", 32'(cs_n), 32'hF);
    wr(8'h18, 32'd2);
    wr(8'h48, 32'h24); get_rx(v);
    chk("R10 held again", 32'(cs_n), 32'hB);
    wr(8'h14, 32'hF);
    chk("R10 default write releases", 32'(cs_n), 32'hF);

    // R11 off mode
    wr(8'h18, 32'd3);
    cs_low_acc = '0;
    wr(8'h48, 32'h44); get_rx(v);
    chk("R11 no line asserted", 32'(cs_low_acc), 32'h0);
    wr(8'h18, 32'd0);

    // R12 default level
    wr(8'h10, 32'd0);
    wr(8'h14, 32'hE);
    chk("R12 idle level applied next cycle", 32'(cs_n), 32'hE);
    cs_hi_acc = '0;
    wr(8'h48, 32'h66); get_rx(v);
    chk("R12 active level inverted", 32'(cs_hi_acc[0]), 32'h1);
    chk("R12 back to idle level", 32'(cs_n), 32'hE);
    wr(8'h14, 32'hF);

    // R13 ignored registers
    wr(8'h60, 32'h1); wr(8'h28, 32'hFFFF_FFFF); wr(8'h70, 32'hFF);
    rd(8'h60, v); chk("R13 flash control reads 0", v, 32'h0);
    rd(8'h00, v); chk("R13 divisor untouched", v, 32'h1);
    rd(8'h40, v); chk("R13 format untouched", v, 32'h0008_0000);
    chk("R13 cs untouched", 32'(cs_n), 32'hF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule